// File: doc/BRIEF.md
# Dual-Buffer Isochronous Receive Splitter

This block sits behind an isochronous receive path and sorts the quadlets of every incoming packet into two memory areas. The first `hdr_quads` quadlets of a packet form its header part and land in a header buffer. Every later quadlet is payload and is appended to a payload buffer. Payload from back-to-back packets forms one unbroken stream. Both buffers come from the current descriptor, which the surrounding logic hands in through a valid/ready port as a base address and a size, each counted in quadlets.

A descriptor is finished, or retired, as soon as one of its two buffers has no room left. When the payload buffer runs out part-way through a packet, the rest of that packet continues at the base of the next descriptor's payload buffer. When the header buffer runs out, the block moves to a new descriptor, and whatever payload space was still free in the old one stays unused. Each retirement produces a one-cycle completion record. If no descriptor is loaded, the block applies backpressure on its input instead of dropping data.

Top module: `isr_dualbuf_splitter`

## Requirements
- R1: After reset, `in_ready`, `wr_en` and `done_valid` are low and `desc_ready` is high.
- R2: The first `hdr_quads` quadlets of each packet are written, in order, to the header base plus the number of header quadlets already written into the current descriptor.
- R3: Every quadlet after the header part is written to the payload base plus the number of payload quadlets already written into the current descriptor. Payload of consecutive packets is contiguous.
- R4: When the payload count reaches the payload size, the descriptor is retired with cause bit 0. If this happens inside a packet, the remaining payload of that packet continues at the next descriptor's payload base.
- R5: When a packet ends and the header space left is smaller than `hdr_quads`, the descriptor is retired with cause bit 1. The next payload quadlet goes to the new descriptor's payload base.
- R6: Each retirement gives exactly one `done_valid` pulse. The record carries the header quadlet count, the payload quadlet count and the cause bit (1 = header buffer, 0 = payload buffer). The counts restart at zero for every descriptor.
- R7: A packet of exactly `hdr_quads` quadlets fills one header slot and writes nothing to the payload buffer.
- R8: A packet shorter than `hdr_quads` stores its quadlets in a header slot, fills the rest of that slot with zero quadlets, and writes no payload.
- R9: While no descriptor is loaded, `in_ready` stays low, `desc_ready` stays high and no write is issued.
- R10: A descriptor whose payload size is zero, or whose header size is below `hdr_quads`, is retired at once with both counts zero. A zero payload size takes cause 0; otherwise the cause is 1.
- R11: Header lengths from 1 up to the parameter limit are accepted. `hdr_quads` may only change between packets.
- R12: If a packet end fills both buffers at the same time, the cause bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_quads | input | HLEN_W | Header part length in quadlets (non-zero) |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor slot empty |
| desc_hdr_base | input | ADDR_W | Header buffer base address (quadlet units) |
| desc_hdr_size | input | SIZE_W | Header buffer size in quadlets |
| desc_pay_base | input | ADDR_W | Payload buffer base address (quadlet units) |
| desc_pay_size | input | SIZE_W | Payload buffer size in quadlets |
| in_valid | input | 1 | Quadlet offered |
| in_ready | output | 1 | Quadlet accepted when valid |
| in_data | input | 32 | Packet quadlet |
| in_sop | input | 1 | First quadlet of a packet |
| in_eop | input | 1 | Last quadlet of a packet |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Memory write address (quadlet units) |
| wr_data | output | 32 | Memory write data |
| done_valid | output | 1 | Completion record valid, one cycle |
| done_hdr_cnt | output | SIZE_W | Header quadlets written to the retired descriptor |
| done_pay_cnt | output | SIZE_W | Payload quadlets written to the retired descriptor |
| done_hdr_cause | output | 1 | 1 = header buffer full, 0 = payload buffer full |

## Verification
The bench fills the payload buffer in the middle of a packet. A design that drops or rewinds the leftover quadlets there would write them to the wrong address or lose them. It sends a short packet, which checks that the slot is zero-padded; without padding, every later header would slide out of step. Descriptors of zero size, and a packet end that fills both buffers at once, exercise the cause priority; a design that picks the wrong cause or retires twice produces mismatching records. A deliberate descriptor drought shows whether the block keeps accepting data with nowhere to put it. Finally, switching to a one-quadlet header checks that header length is not fixed at three.

// File: rtl/isr_pkg.sv
package isr_pkg;

   // cause of a retirement, as seen on done_hdr_cause
   typedef enum logic {
      CAUSE_PAY = 1'b0,
      CAUSE_HDR = 1'b1
   } isr_cause_e;

endpackage

// File: rtl/isr_fill_cnt.sv
// Fill counter for one buffer: counts quadlets written and flags when the
// next unit of `need` quadlets would no longer fit.
module isr_fill_cnt #(
   parameter int SIZE_W = 10,
   parameter int NEED_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   input  logic [SIZE_W-1:0] size,
   input  logic [NEED_W-1:0] need,
   output logic [SIZE_W-1:0] cnt,
   output logic              full
);
   localparam int SUM_W = SIZE_W + 1;

   generate
      if (NEED_W > SIZE_W) begin : g_bad_need
         $error("isr_fill_cnt: NEED_W must not exceed SIZE_W");
      end
   endgenerate

   logic [SUM_W-1:0] reach;

   assign reach = SUM_W'(cnt) + SUM_W'(need);
   assign full  = reach > SUM_W'(size);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + SIZE_W'(1);
   end

   // a write never lands beyond the end of its buffer
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |-> (SUM_W'(cnt) < SUM_W'(size)));

endmodule

// File: rtl/isr_wr_stage.sv
// Registered memory write port; RESET_DATA selects whether the address and
// data flops carry a reset or are plain data flops.
module isr_wr_stage #(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 32,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              we_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) we_o <= 1'b0;
      else        we_o <= we_i;
   end

   generate
      if (RESET_DATA) begin : g_rst_data
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               addr_o <= '0;
               data_o <= '0;
            end else begin
               addr_o <= addr_i;
               data_o <= data_i;
            end
         end
      end else begin : g_plain_data
         always_ff @(posedge clk) begin
            addr_o <= addr_i;
            data_o <= data_i;
         end
      end
   endgenerate

endmodule

// File: rtl/isr_dualbuf_splitter.sv
module isr_dualbuf_splitter
   import isr_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int SIZE_W     = 10,
   parameter int HLEN_W     = 3,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HLEN_W-1:0] hdr_quads,
   input  logic              desc_valid,
   output logic              desc_ready,
   input  logic [ADDR_W-1:0] desc_hdr_base,
   input  logic [SIZE_W-1:0] desc_hdr_size,
   input  logic [ADDR_W-1:0] desc_pay_base,
   input  logic [SIZE_W-1:0] desc_pay_size,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [31:0]       in_data,
   input  logic              in_sop,
   input  logic              in_eop,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [31:0]       wr_data,
   output logic              done_valid,
   output logic [SIZE_W-1:0] done_hdr_cnt,
   output logic [SIZE_W-1:0] done_pay_cnt,
   output logic              done_hdr_cause
);
   localparam int QUAD_W = 32;

   generate
      if (SIZE_W > ADDR_W) begin : g_bad_size
         $error("isr_dualbuf_splitter: SIZE_W must not exceed ADDR_W");
      end
      if (HLEN_W < 1 || HLEN_W > SIZE_W) begin : g_bad_hlen
         $error("isr_dualbuf_splitter: HLEN_W out of range");
      end
   endgenerate

   // current descriptor
   logic              cur_valid;
   logic [ADDR_W-1:0] hb_q, pb_q;
   logic [SIZE_W-1:0] hs_q, ps_q;

   // packet tracking
   logic              in_pkt;
   logic [HLEN_W-1:0] hdr_idx, idx_nxt, pad_rem;

   logic [SIZE_W-1:0] hdr_cnt, pay_cnt;
   logic              hdr_full, pay_full;

   logic              padding, retire, load, fire, beat_hdr, hdr_inc, pay_inc;
   logic              wq_we;
   logic [ADDR_W-1:0] wq_addr;
   logic [QUAD_W-1:0] wq_data;
   isr_cause_e        cause;

   assign padding    = pad_rem != '0;
   assign retire     = cur_valid && !padding && (pay_full || (hdr_full && !in_pkt));
   assign desc_ready = !cur_valid;
   assign load       = desc_valid && !cur_valid;
   assign in_ready   = cur_valid && !padding && !retire;
   assign fire       = in_valid && in_ready;
   assign beat_hdr   = in_sop || (in_pkt && (hdr_idx < hdr_quads));
   assign idx_nxt    = in_sop ? HLEN_W'(1) : hdr_idx + HLEN_W'(1);
   assign hdr_inc    = (fire && beat_hdr) || padding;
   assign pay_inc    = fire && !beat_hdr;
   assign cause      = pay_full ? CAUSE_PAY : CAUSE_HDR;

   always_comb begin
      wq_we   = hdr_inc || pay_inc;
      wq_addr = hdr_inc ? hb_q + ADDR_W'(hdr_cnt) : pb_q + ADDR_W'(pay_cnt);
      wq_data = padding ? '0 : in_data;
   end

   isr_fill_cnt #(.SIZE_W(SIZE_W), .NEED_W(HLEN_W)) i_hdr_fill (
      .clk (clk), .rst_n (rst_n), .clr (load), .inc (hdr_inc),
      .size (hs_q), .need (hdr_quads), .cnt (hdr_cnt), .full (hdr_full)
   );

   isr_fill_cnt #(.SIZE_W(SIZE_W), .NEED_W(1)) i_pay_fill (
      .clk (clk), .rst_n (rst_n), .clr (load), .inc (pay_inc),
      .size (ps_q), .need (1'b1), .cnt (pay_cnt), .full (pay_full)
   );

   isr_wr_stage #(.ADDR_W(ADDR_W), .DATA_W(QUAD_W), .RESET_DATA(RESET_DATA)) i_wr (
      .clk (clk), .rst_n (rst_n),
      .we_i (wq_we), .addr_i (wq_addr), .data_i (wq_data),
      .we_o (wr_en), .addr_o (wr_addr), .data_o (wr_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_valid      <= 1'b0;
         hb_q           <= '0;
         pb_q           <= '0;
         hs_q           <= '0;
         ps_q           <= '0;
         in_pkt         <= 1'b0;
         hdr_idx        <= '0;
         pad_rem        <= '0;
         done_valid     <= 1'b0;
         done_hdr_cnt   <= '0;
         done_pay_cnt   <= '0;
         done_hdr_cause <= 1'b0;
      end else begin
         done_valid <= retire;
         if (retire) begin
            done_hdr_cnt   <= hdr_cnt;
            done_pay_cnt   <= pay_cnt;
            done_hdr_cause <= cause;
            cur_valid      <= 1'b0;
         end else if (load) begin
            cur_valid <= 1'b1;
            hb_q      <= desc_hdr_base;
            hs_q      <= desc_hdr_size;
            pb_q      <= desc_pay_base;
            ps_q      <= desc_pay_size;
         end
         if (padding) pad_rem <= pad_rem - HLEN_W'(1);
         if (fire) begin
            if (beat_hdr) hdr_idx <= idx_nxt;
            if (in_eop) begin
               in_pkt <= 1'b0;
               if (beat_hdr && (idx_nxt < hdr_quads)) pad_rem <= hdr_quads - idx_nxt;
            end else begin
               in_pkt <= 1'b1;
            end
         end
      end
   end

   // one record per retirement, never two in a row
   p_one_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);

   // counts restart with every new descriptor
   p_fresh_counts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (hdr_cnt == '0 && pay_cnt == '0));

   // a full payload buffer retires with cause 0 (also wins over a full header)
   p_pay_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_valid && pay_full && !padding) |=> (done_valid && !done_hdr_cause));

   // a full header buffer between packets retires with cause 1
   p_hdr_retire_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_valid && hdr_full && !pay_full && !in_pkt && !padding)
      |=> (done_valid && done_hdr_cause));

   // header length must be a real length while a descriptor is live
   p_hdr_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cur_valid |-> (hdr_quads != '0));

endmodule

// File: tb/test_isr_dualbuf_splitter.sv
module test_isr_dualbuf_splitter;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 16;
   localparam int SIZE_W = 10;
   localparam int HLEN_W = 3;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [HLEN_W-1:0] hdr_quads;
   logic              desc_valid, desc_ready;
   logic [ADDR_W-1:0] desc_hdr_base, desc_pay_base;
   logic [SIZE_W-1:0] desc_hdr_size, desc_pay_size;
   logic              in_valid, in_ready, in_sop, in_eop;
   logic [31:0]       in_data;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [31:0]       wr_data;
   logic              done_valid, done_hdr_cause;
   logic [SIZE_W-1:0] done_hdr_cnt, done_pay_cnt;

   always #(CLK_PERIOD/2) clk = ~clk;

   isr_dualbuf_splitter #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .HLEN_W(HLEN_W)) i_isr_dualbuf_splitter (
      .clk, .rst_n, .hdr_quads, .desc_valid, .desc_ready, .desc_hdr_base, .desc_hdr_size,
      .desc_pay_base, .desc_pay_size, .in_valid, .in_ready, .in_data, .in_sop, .in_eop,
      .wr_en, .wr_addr, .wr_data, .done_valid, .done_hdr_cnt, .done_pay_cnt, .done_hdr_cause
   );

   int n_vec = 0, n_bad = 0, n_wr = 0;
   bit feed_en = 1'b0;

   // descriptor feed queues and model copies
   int dq_hb[$], dq_hs[$], dq_pb[$], dq_ps[$];
   int mq_hb[$], mq_hs[$], mq_pb[$], mq_ps[$];
   // scoreboard queues
   int ew_a[$], ew_d[$]; string ew_t[$];
   int ed_h[$], ed_p[$], ed_c[$]; string ed_t[$];

   // model state
   int mh;
   bit m_have = 1'b0;
   int m_hb, m_hs, m_pb, m_ps, m_hc, m_pc;
   string m_next_pay_tag = "";

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic add_desc(input int hb, input int hs, input int pb, input int ps);
      dq_hb.push_back(hb); dq_hs.push_back(hs); dq_pb.push_back(pb); dq_ps.push_back(ps);
      mq_hb.push_back(hb); mq_hs.push_back(hs); mq_pb.push_back(pb); mq_ps.push_back(ps);
   endtask

   function automatic bit m_pf(); return (m_pc + 1) > m_ps; endfunction
   function automatic bit m_hf(); return (m_hc + mh) > m_hs; endfunction

   task automatic m_load();
      if (!m_have) begin
         m_hb = mq_hb.pop_front(); m_hs = mq_hs.pop_front();
         m_pb = mq_pb.pop_front(); m_ps = mq_ps.pop_front();
         m_hc = 0; m_pc = 0; m_have = 1'b1;
      end
   endtask

   task automatic m_retire(input string tag);
      ed_h.push_back(m_hc); ed_p.push_back(m_pc);
      ed_c.push_back(m_pf() ? 0 : 1); ed_t.push_back(tag);
      m_have = 1'b0;
   endtask

   task automatic push_wr(input int a, input int d, input string tag);
      ew_a.push_back(a); ew_d.push_back(d); ew_t.push_back(tag);
   endtask

   task automatic beat(input logic [31:0] d, input bit s, input bit e);
      bit ok;
      in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
      ok = 1'b0;
      while (!ok) begin
         ok = in_ready;
         @(posedge clk);
         if (!ok) @(negedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
   endtask

   // driver: predicts every write and retirement, then drives the beats
   task automatic send_pkt(input int n, input int base);
      string ptag, htag;
      bit strad;
      while (1'b1) begin
         m_load();
         if (m_pf() || m_hf()) m_retire("R10");
         else break;
      end
      ptag = m_next_pay_tag; m_next_pay_tag = ""; strad = 1'b0;
      htag = (mh == 1) ? "R11" : (n == mh) ? "R7" : (n < mh) ? "R8" : "R2";
      for (int i = 0; i < n; i++) begin
         if (i < mh) begin
            push_wr(m_hb + m_hc, base + i, htag); m_hc++;
         end else begin
            if (m_pf()) begin m_retire("R4"); m_load(); strad = 1'b1; end
            push_wr(m_pb + m_pc, base + i, strad ? "R4" : (ptag != "" ? ptag : "R3"));
            ptag = ""; m_pc++;
         end
      end
      for (int j = n; j < mh; j++) begin push_wr(m_hb + m_hc, 0, "R8"); m_hc++; end
      if (m_pf()) m_retire(m_hf() ? "R12" : "R6");
      else if (m_hf()) begin m_retire("R5"); m_next_pay_tag = "R5"; end
      for (int i = 0; i < n; i++) beat(base + i, i == 0, i == n - 1);
   endtask

   // descriptor feeder
   initial begin
      bit rdy_seen;
      rdy_seen = 1'b0;
      desc_valid = 1'b0; desc_hdr_base = '0; desc_hdr_size = '0;
      desc_pay_base = '0; desc_pay_size = '0;
      forever begin
         @(negedge clk);
         if (desc_valid && rdy_seen && rst_n) begin
            void'(dq_hb.pop_front()); void'(dq_hs.pop_front());
            void'(dq_pb.pop_front()); void'(dq_ps.pop_front());
         end
         if (feed_en && dq_hb.size() > 0) begin
            desc_valid    = 1'b1;
            desc_hdr_base = ADDR_W'(dq_hb[0]); desc_hdr_size = SIZE_W'(dq_hs[0]);
            desc_pay_base = ADDR_W'(dq_pb[0]); desc_pay_size = SIZE_W'(dq_ps[0]);
         end else begin
            desc_valid = 1'b0;
         end
         rdy_seen = desc_ready;
      end
   end

   // monitor: pops expectations as results appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_en) begin
            n_wr++;
            if (ew_a.size() == 0) chk(1'b0, "R3", "unexpected write", {wr_addr, wr_data}, 0);
            else begin
               int a, d; string t;
               a = ew_a.pop_front(); d = ew_d.pop_front(); t = ew_t.pop_front();
               chk(wr_addr == ADDR_W'(a) && wr_data == d, t, "write addr/data",
                   {wr_addr, wr_data}, {ADDR_W'(a), d[31:0]});
            end
         end
         if (done_valid) begin
            if (ed_h.size() == 0) chk(1'b0, "R6", "unexpected record", done_hdr_cnt, 0);
            else begin
               int h, p, c; string t;
               h = ed_h.pop_front(); p = ed_p.pop_front(); c = ed_c.pop_front(); t = ed_t.pop_front();
               chk(done_hdr_cnt == SIZE_W'(h) && done_pay_cnt == SIZE_W'(p) && done_hdr_cause == c[0],
                   t, "record hdr/pay/cause",
                   {done_hdr_cnt, done_pay_cnt, 3'b0, done_hdr_cause},
                   {SIZE_W'(h), SIZE_W'(p), 3'b0, c[0]});
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
      hdr_quads = HLEN_W'(3); mh = 3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(!in_ready && desc_ready && !wr_en && !done_valid, "R1", "reset outputs",
          {in_ready, desc_ready, wr_en, done_valid}, 4'b0100);

      add_desc('h100, 9, 'h200, 8);
      add_desc('h300, 6, 'h400, 16);
      add_desc('h500, 2, 'h600, 4);   // header too small: R10
      add_desc('h700, 0, 'h800, 0);   // both zero: R10, cause 0
      add_desc('h900, 3, 'hA00, 2);   // both fill at once: R12
      feed_en = 1'b1;

      send_pkt(7, 'h1100_0000);  // R2, R3
      send_pkt(3, 'h2200_0000);  // R7 empty packet
      send_pkt(9, 'h3300_0000);  // R4 straddle
      send_pkt(4, 'h4400_0000);
      send_pkt(2, 'h5500_0000);  // R8 short, then R5 header full
      send_pkt(5, 'h6600_0000);  // R10 twice, R5 gap, R12

      // R9: no descriptor available
      feed_en = 1'b0;
      add_desc('hB00, 12, 'hC00, 32);
      fork
         send_pkt(5, 'h7700_0000);
         begin
            int w0; bit stall_ok;
            repeat (4) @(negedge clk);
            w0 = n_wr; stall_ok = 1'b1;
            repeat (10) begin
               @(negedge clk);
               if (in_ready || !desc_ready) stall_ok = 1'b0;
            end
            chk(stall_ok && n_wr == w0, "R9", "stall without descriptor",
                {stall_ok, n_wr[15:0]}, {1'b1, w0[15:0]});
            feed_en = 1'b1;
         end
      join

      // R11: one-quadlet header
      hdr_quads = HLEN_W'(1); mh = 1;
      send_pkt(4, 'h8800_0000);
      send_pkt(1, 'h9900_0000);
      send_pkt(6, 'hAA00_0000);

      repeat (20) @(negedge clk);
      chk(ew_a.size() == 0 && ed_h.size() == 0, "R6", "all expected results seen",
          {ew_a.size(), ed_h.size()}, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule